// File: doc/BRIEF.md
# Reference Clock Failover Controller

This block supervises two single-ended reference clocks and decides which of them feeds a downstream PLL. It runs on a free-running monitor clock that is faster than either reference. Each reference is brought into the monitor domain through a two-flop synchroniser. A rising-edge detector restarts a per-input timeout counter on every edge. A reference that produces no rising edge for a parameterised number of monitor cycles is declared failed, and its active-low alarm drops.

In automatic mode a failure on the primary reference moves the selection to the other input, provided that input is healthy. The primary reference is set by a select input. An active-low alarm clear releases both alarms and returns the selection to the primary reference. Manual mode and PLL bypass each turn the supervision off. In either case the selection simply follows the primary-select input. The block drives a select line for an external glitch-free clock multiplexer and a matching indicator of the active reference.

Top module: `refclk_failover`

## Requirements
- R1: While `autoMode` is low, no failure is detected, both alarm outputs stay high and the selection follows `primarySel`, whatever the reference clocks do.
- R2: `primarySel` = 0 names reference A as primary and 1 names reference B. `activeInd` is 0 while A is selected and 1 while B is selected. `muxSel` always equals `activeInd`.
- R3: `alarmAN` is low exactly while reference A is flagged as failed, and `alarmBN` is low exactly while reference B is flagged. Both are high otherwise.
- R4: A reference is flagged once no rising edge of it has been seen for `TIMEOUT` monitor cycles (default 64). A reference toggling with a period well below `TIMEOUT` never raises an alarm. A stopped reference is not flagged sooner than about `TIMEOUT` cycles after its last edge.
- R5: In automatic mode, when the primary reference is flagged and the other is not, the selection moves to the other reference.
- R6: Once raised, an alarm stays low even if its reference starts toggling again, until the alarm clear or an inactive mode releases it.
- R7: While `alarmClrN` is low in automatic mode, both alarms are released and held released, the selection equals `primarySel`, and the timeout counters restart.
- R8: While `bypassPll` is high, the block behaves as in manual mode: alarms high and selection following `primarySel`.
- R9: The block never switches onto a flagged reference. When both references are flagged, the current selection is held.
- R10: While `rst` is high, and on the cycle after it falls, both alarms are high and the selection equals `primarySel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock, faster than either reference |
| rst | input | 1 | Active-high synchronous reset |
| refA | input | 1 | Reference clock A, asynchronous to `clk` |
| refB | input | 1 | Reference clock B, asynchronous to `clk` |
| autoMode | input | 1 | 1 = automatic supervision and switchover, 0 = manual |
| bypassPll | input | 1 | 1 = PLL bypassed, supervision disabled |
| primarySel | input | 1 | Primary reference: 0 = A, 1 = B |
| alarmClrN | input | 1 | Active-low alarm clear and selection restore |
| alarmAN | output | 1 | Low while reference A is flagged as failed |
| alarmBN | output | 1 | Low while reference B is flagged as failed |
| activeInd | output | 1 | Active reference indicator: 0 = A, 1 = B |
| muxSel | output | 1 | Select line for the external clock multiplexer, same encoding |

## Verification
The alarm clear and timeout detection can act in the same cycle. A stopped reference keeps producing expiry while the clear is held. The bench provokes this by holding `alarmClrN` low for far longer than `TIMEOUT` with reference A stopped. It judges the result by requiring `alarmAN` to stay high and the selection to stay on the primary reference throughout. It also checks that once the clear is released, the same stopped reference goes on to drive the normal failover path.

// File: rtl/failover_pkg.sv
package failover_pkg;
  localparam int NUM_REFS = 2;

  // strobes from control to the monitoring datapath
  typedef struct packed {
    logic                monEnable;
    logic [NUM_REFS-1:0] restart;
  } dpCtl_t;
endpackage

// File: rtl/failover_datapath.sv
module failover_datapath
  import failover_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] refIn,
  input  dpCtl_t              ctl,
  output logic [NUM_REFS-1:0] expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    logic          syncA, syncB, prevLvl;
    logic          riseSeen;
    logic [CW-1:0] idleCnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncA   <= 1'b0;
        syncB   <= 1'b0;
        prevLvl <= 1'b0;
      end else begin
        syncA   <= refIn[i];
        syncB   <= syncA;
        prevLvl <= syncB;
      end
    end

    assign riseSeen = syncB & ~prevLvl;

    always_ff @(posedge clk) begin
      if (rst || !ctl.monEnable || ctl.restart[i] || riseSeen)
        idleCnt <= '0;
      else if (idleCnt != LIMIT)
        idleCnt <= idleCnt + 1'b1;
    end

    assign expired[i] = (idleCnt == LIMIT);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      idleCnt <= LIMIT);  // R4
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      !ctl.monEnable |=> !expired[i]);  // R1
  end
endmodule

// File: rtl/failover_control.sv
module failover_control
  import failover_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                autoMode,
  input  logic                bypassPll,
  input  logic                primarySel,
  input  logic                alarmClrN,
  input  logic [NUM_REFS-1:0] expired,
  output dpCtl_t              ctl,
  output logic [NUM_REFS-1:0] alarm,
  output logic                sel
);
  logic active, clearing;
  logic [NUM_REFS-1:0] alarmNext;
  logic selNext;

  assign active   = autoMode & ~bypassPll;
  assign clearing = ~alarmClrN;

  always_comb begin
    ctl.monEnable = active;
    ctl.restart   = {NUM_REFS{clearing}};
  end

  always_comb begin
    if (!active || clearing) alarmNext = '0;
    else                     alarmNext = alarm | expired;
  end

  always_comb begin
    if (!active || clearing)  selNext = primarySel;
    else if (&alarm)          selNext = sel;
    else if (alarm[primarySel]) selNext = ~primarySel;
    else                      selNext = primarySel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm <= '0;
      sel   <= primarySel;
    end else begin
      alarm <= alarmNext;
      sel   <= selNext;
    end
  end

  AST_INACTIVE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !active |=> alarm == '0);  // R1
  AST_INACTIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !active |=> sel == $past(primarySel));  // R8
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    clearing |=> alarm == '0);  // R7
  AST_ALARM_LATCHED: assert property (@(posedge clk) disable iff (rst)
    active && !clearing && alarm[0] |=> alarm[0]);  // R6
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    active && !clearing && (&alarm) |=> $stable(sel));  // R9
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import failover_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic refA,
  input  logic refB,
  input  logic autoMode,
  input  logic bypassPll,
  input  logic primarySel,
  input  logic alarmClrN,
  output logic alarmAN,
  output logic alarmBN,
  output logic activeInd,
  output logic muxSel
);
  dpCtl_t ctl;
  logic [NUM_REFS-1:0] expired;
  logic [NUM_REFS-1:0] alarm;
  logic sel;

  failover_datapath #(.TIMEOUT(TIMEOUT)) u_dp (
    .clk(clk), .rst(rst), .refIn({refB, refA}), .ctl(ctl), .expired(expired)
  );

  failover_control u_ctl (
    .clk(clk), .rst(rst), .autoMode(autoMode), .bypassPll(bypassPll),
    .primarySel(primarySel), .alarmClrN(alarmClrN), .expired(expired),
    .ctl(ctl), .alarm(alarm), .sel(sel)
  );

  assign alarmAN   = ~alarm[0];
  assign alarmBN   = ~alarm[1];
  assign activeInd = sel;
  assign muxSel    = sel;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> alarmAN && alarmBN);  // R10
endmodule

// File: tb/sim_refclk_failover.sv
module sim_refclk_failover;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refA = 1'b0, refB = 1'b0;
  logic runA = 1'b1, runB = 1'b1;
  logic autoMode = 1'b1, bypassPll = 1'b0, primarySel = 1'b0, alarmClrN = 1'b1;
  logic alarmAN, alarmBN, activeInd, muxSel;
  int   nChecks = 0, nFails = 0;
  int   divCnt = 0;
  int   cycles = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  refclk_failover u0 (
    .clk(clk), .rst(rst), .refA(refA), .refB(refB), .autoMode(autoMode),
    .bypassPll(bypassPll), .primarySel(primarySel), .alarmClrN(alarmClrN),
    .alarmAN(alarmAN), .alarmBN(alarmBN), .activeInd(activeInd), .muxSel(muxSel)
  );

  // references toggle every 3 monitor cycles (period 6) while running
  always @(negedge clk) begin
    if (divCnt == 2) begin
      divCnt <= 0;
      if (runA) refA <= ~refA;
      if (runB) refB <= ~refB;
    end else begin
      divCnt <= divCnt + 1;
    end
  end

  // vector: {auto, bypass, prim, runA, runB, clr, expAN, expBN, expInd}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    9'b100110_110,  // 0  R2 healthy, primary A
    9'b101110_111,  // 1  R2 primary B selected
    9'b100010_011,  // 2  R5 A stops, move to B
    9'b100110_011,  // 3  R6 A resumes, alarm stays
    9'b100111_110,  // 4  R7 clear restores A
    9'b100100_100,  // 5  R3 B stops, A kept
    9'b100000_000,  // 6  R9 both failed, hold A
    9'b100111_110,  // 7  R7 clear with both running
    9'b101100_100,  // 8  R5 primary B fails, move to A
    9'b001100_111,  // 9  R1 manual: alarms off, follow primary
    9'b000100_110,  // 10 R1 manual follow primary A
    9'b110000_110,  // 11 R8 bypass: no alarms
    9'b111000_111,  // 12 R8 bypass follows primary B
    9'b100111_110   // 13 R7 back to auto, cleared
  };

  function automatic string vecTag(int idx);
    case (idx)
      0, 1:      return "R2";
      2, 8:      return "R5";
      3:         return "R6";
      4, 7, 13:  return "R7";
      5:         return "R3";
      6:         return "R9";
      9, 10:     return "R1";
      default:   return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {alarmAN,alarmBN,activeInd,muxSel} = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {alarmAN, alarmBN, activeInd, muxSel};
  endfunction

  initial begin
    waitCycles(4);
    check("R10", outs(), 4'b1100);  // during reset, primary A
    rst = 1'b0;
    waitCycles(1);
    check("R10", outs(), 4'b1100);

    for (int v = 0; v < NV; v++) begin
      autoMode   = VEC[v][8];
      bypassPll  = VEC[v][7];
      primarySel = VEC[v][6];
      runA       = VEC[v][5];
      runB       = VEC[v][4];
      if (VEC[v][3]) begin
        alarmClrN = 1'b0;
        waitCycles(4);
        alarmClrN = 1'b1;
      end
      waitCycles(200);
      check(vecTag(v), outs(),
            {VEC[v][2], VEC[v][1], VEC[v][0], VEC[v][0]});
    end

    // R4 boundary: stopped A not flagged before ~TIMEOUT cycles, flagged after
    runA = 1'b0;
    waitCycles(40);
    check("R4", outs(), 4'b1100);
    waitCycles(60);
    check("R4", outs(), 4'b0111);

    // R7 clear held while A stays stopped: clear dominates detection
    alarmClrN = 1'b0;
    waitCycles(150);
    check("R7", outs(), 4'b1100);
    alarmClrN = 1'b1;
    waitCycles(120);
    check("R5", outs(), 4'b0111);

    // R10 reset with primary B restores release and selection
    primarySel = 1'b1;
    rst = 1'b1;
    waitCycles(3);
    check("R10", outs(), 4'b1111);
    rst = 1'b0;
    waitCycles(1);
    check("R10", outs(), 4'b1111);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: cycles = %0d, expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule